// File: doc/BRIEF.md
# Byte Arithmetic Unit with Full Product

This block is a purely combinational arithmetic unit for a small datapath. It takes two byte operands and a two-bit function code, and returns a 16-bit result together with two flags:

- a zero flag, computed over the entire result;
- an overflow flag, which reads the operands as two's-complement numbers.

The four functions are:

- modular addition;
- bitwise exclusive-or;
- forwarding of the second operand;
- an unsigned 8x8 multiply that uses all sixteen result bits.

The surrounding datapath owns all storage and all sequencing. It drives operands and a function code, and picks up the result and flags once the logic has settled. No clock reaches the block. Subtraction and other derived operations are built outside, from sequences of these four functions.

Top module: `byte_arith_unit`

## Requirements
- R1: With function code 2'b00, res_o[7:0] equals (a_i + b_i) mod 256, and the carry out of bit 7 does not appear on res_o[8].
- R2: With function code 2'b01, res_o[7:0] equals a_i XOR b_i.
- R3: With function code 2'b10, res_o[7:0] equals b_i, whatever a_i holds.
- R4: With function code 2'b11, res_o[15:0] equals the unsigned product a_i * b_i.
- R5: For codes 2'b00, 2'b01 and 2'b10, res_o[15:8] is zero.
- R6: zero_o is 1 exactly when all 16 bits of res_o are 0, for every function code.
- R7: For code 2'b00, ovf_o is 1 exactly when a_i[7] equals b_i[7] and bit 7 of the 8-bit sum differs from them.
- R8: For codes 2'b01 and 2'b10, ovf_o is 0.
- R9: For code 2'b11, ovf_o is 1 exactly when the product of a_i and b_i, both read as signed bytes, lies outside -128..127.
- R10: All outputs follow input changes without any clock edge and hold no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| func_i | input | 2 | Function code: 00 add, 01 xor, 10 pass second operand, 11 multiply |
| res_o | output | 16 | Result |
| zero_o | output | 1 | Result is all zero |
| ovf_o | output | 1 | Signed overflow of the selected function |

## Verification
The block holds no state, so any fault appears at the ports within the same evaluation as the stimulus that triggers it. A fault can take several forms:

- A wrong partial-product row or a wrong carry position shows up as a corrupted result for particular operand bit patterns only. For that reason the vectors include all-ones, sign-bit-only and single-bit operands.
- A fault in the result-select path leaks multiply bits into the upper byte for the narrow functions.
- Flag faults show at the edges of the sign range, such as 127+1, -128*-1 and -128*1, and on results that are exactly zero.

// File: rtl/byte_arith_pkg.sv
package byte_arith_pkg;
  localparam int unsigned OPW = 8;
  localparam int unsigned RESW = 2 * OPW;

  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_XOR  = 2'b01,
    FN_PASS = 2'b10,
    FN_MUL  = 2'b11
  } func_e;
endpackage

// File: rtl/bau_add_unit.sv
module bau_add_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W:0] full_sum;

  assign full_sum = {1'b0, a_i} + {1'b0, b_i};
  // carry bit deliberately dropped
  assign sum_o = full_sum[W-1:0];
  assign ovf_o = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/bau_mul_array.sv
module bau_mul_array #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o,
  output logic           ovf_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] acc [0:W];
  logic [PW-1:0] a_ext;
  logic [PW-1:0] sgn_fix_a;
  logic [PW-1:0] sgn_fix_b;
  logic [PW-1:0] prod_s;
  logic [W:0]    top_bits;

  assign a_ext  = {{W{1'b0}}, a_i};
  assign acc[0] = '0;

  // shift-and-add rows, one per multiplier bit
  for (genvar i = 0; i < W; i++) begin : g_row
    assign acc[i+1] = acc[i] + (b_i[i] ? (a_ext << i) : '0);
  end

  assign prod_o = acc[W];

  // signed product from unsigned one: subtract 2^W * other operand per negative sign
  assign sgn_fix_a = a_i[W-1] ? {b_i, {W{1'b0}}} : '0;
  assign sgn_fix_b = b_i[W-1] ? {a_i, {W{1'b0}}} : '0;
  assign prod_s    = acc[W] - sgn_fix_a - sgn_fix_b;
  assign top_bits  = prod_s[PW-1:W-1];
  assign ovf_o     = !((&top_bits) || !(|top_bits));
endmodule

// File: rtl/bau_flag_unit.sv
module bau_flag_unit #(
  parameter int unsigned RW = 16
) (
  input  logic [RW-1:0] res_i,
  input  logic [1:0]    func_i,
  input  logic          add_ovf_i,
  input  logic          mul_ovf_i,
  output logic          zero_o,
  output logic          ovf_o
);
  import byte_arith_pkg::*;

  assign zero_o = ~|res_i;

  always_comb begin
    unique case (func_e'(func_i))
      FN_ADD:  ovf_o = add_ovf_i;
      FN_MUL:  ovf_o = mul_ovf_i;
      default: ovf_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_arith_unit.sv
module byte_arith_unit
  import byte_arith_pkg::*;
(
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  input  logic [1:0]      func_i,
  output logic [RESW-1:0] res_o,
  output logic            zero_o,
  output logic            ovf_o
);
  logic [OPW-1:0]  sum;
  logic [RESW-1:0] prod;
  logic            add_ovf;
  logic            mul_ovf;
  logic [OPW-1:0]  narrow;

  bau_add_unit #(.W(OPW)) u_add (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum),
    .ovf_o (add_ovf)
  );

  bau_mul_array #(.W(OPW)) u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod),
    .ovf_o  (mul_ovf)
  );

  always_comb begin
    unique case (func_e'(func_i))
      FN_ADD:  narrow = sum;
      FN_XOR:  narrow = a_i ^ b_i;
      default: narrow = b_i;
    endcase
  end

  assign res_o = (func_e'(func_i) == FN_MUL) ? prod : {{OPW{1'b0}}, narrow};

  bau_flag_unit #(.RW(RESW)) u_flag (
    .res_i     (res_o),
    .func_i    (func_i),
    .add_ovf_i (add_ovf),
    .mul_ovf_i (mul_ovf),
    .zero_o    (zero_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/byte_arith_unit_chk.sv
module byte_arith_unit_chk
  import byte_arith_pkg::*;
(
  input logic [OPW-1:0]  a_i,
  input logic [OPW-1:0]  b_i,
  input logic [1:0]      func_i,
  input logic [RESW-1:0] res_o,
  input logic            zero_o,
  input logic            ovf_o
);
  logic signed [RESW-1:0] sprod;
  logic [OPW-1:0]         s8;

  always_comb begin
    sprod = RESW'($signed(a_i)) * RESW'($signed(b_i));
    s8    = a_i + b_i;

    if (func_i == 2'b00) begin
      // R1
      add_sum_chk: assert (res_o == {8'h00, s8});
      // R7
      add_ovf_chk: assert (ovf_o == ((a_i[7] == b_i[7]) && (s8[7] != a_i[7])));
    end

    if (func_i == 2'b01) begin
      // R2
      xor_res_chk: assert (res_o[7:0] == (a_i ^ b_i));
    end

    if (func_i == 2'b10) begin
      // R3
      pass_res_chk: assert (res_o[7:0] == b_i);
    end

    if (func_i == 2'b11) begin
      // R4
      mul_res_chk: assert (res_o == RESW'(a_i) * RESW'(b_i));
      // R9
      mul_ovf_chk: assert (ovf_o == ((sprod > 16'sd127) || (sprod < -16'sd128)));
    end

    if (func_i != 2'b11) begin
      // R5
      upper_clear_chk: assert (res_o[15:8] == 8'h00);
    end

    if (func_i == 2'b01 || func_i == 2'b10) begin
      // R8
      no_overflow_chk: assert (!ovf_o);
    end

    // R6
    zero_flag_chk: assert (zero_o == (res_o == '0));
  end
endmodule

bind byte_arith_unit byte_arith_unit_chk u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .func_i (func_i),
  .res_o  (res_o),
  .zero_o (zero_o),
  .ovf_o  (ovf_o)
);

// File: tb/tb_byte_arith_unit.sv
module tb_byte_arith_unit;
  logic        clk;
  logic        rst_ni;
  logic [7:0]  a_i;
  logic [7:0]  b_i;
  logic [1:0]  func_i;
  logic [15:0] res_o;
  logic        zero_o;
  logic        ovf_o;

  int n_chk;
  int n_fail;
  bit done;

  byte_arith_unit dut (
    .a_i    (a_i),
    .b_i    (b_i),
    .func_i (func_i),
    .res_o  (res_o),
    .zero_o (zero_o),
    .ovf_o  (ovf_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {func, a, b, exp_res, exp_zero, exp_ovf}
  localparam logic [35:0] VEC [0:14] = '{
    {2'b00, 8'h05, 8'h03, 16'h0008, 1'b0, 1'b0},
    {2'b00, 8'hFF, 8'h01, 16'h0000, 1'b1, 1'b0},
    {2'b00, 8'h7F, 8'h01, 16'h0080, 1'b0, 1'b1},
    {2'b00, 8'h80, 8'h80, 16'h0000, 1'b1, 1'b1},
    {2'b00, 8'h80, 8'hFF, 16'h007F, 1'b0, 1'b1},
    {2'b01, 8'hA5, 8'hA5, 16'h0000, 1'b1, 1'b0},
    {2'b01, 8'hF0, 8'h0F, 16'h00FF, 1'b0, 1'b0},
    {2'b10, 8'h12, 8'h00, 16'h0000, 1'b1, 1'b0},
    {2'b10, 8'h80, 8'h80, 16'h0080, 1'b0, 1'b0},
    {2'b11, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b0},
    {2'b11, 8'h10, 8'h10, 16'h0100, 1'b0, 1'b1},
    {2'b11, 8'h00, 8'hAB, 16'h0000, 1'b1, 1'b0},
    {2'b11, 8'h80, 8'h01, 16'h0080, 1'b0, 1'b0},
    {2'b11, 8'h80, 8'hFF, 16'h7F80, 1'b0, 1'b1},
    {2'b11, 8'h0C, 8'h0A, 16'h0078, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: func=%b a=%h b=%h actual=%h expected=%h", req, func_i, a_i, b_i, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] f, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    func_i = f;
    a_i    = a;
    b_i    = b;
    #1;
  endtask

  function automatic logic [17:0] model(input logic [1:0] f, input logic [7:0] a, input logic [7:0] b);
    logic [15:0] r;
    logic        v;
    int          sp;
    case (f)
      2'b00: begin
        r = {8'h00, 8'(a + b)};
        v = (a[7] == b[7]) && (r[7] != a[7]);
      end
      2'b01: begin r = {8'h00, a ^ b}; v = 1'b0; end
      2'b10: begin r = {8'h00, b}; v = 1'b0; end
      default: begin
        r  = 16'(a) * 16'(b);
        sp = int'($signed(a)) * int'($signed(b));
        v  = (sp > 127) || (sp < -128);
      end
    endcase
    return {r, (r == 16'h0), v};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [17:0] e;
    logic [7:0]  lfsr;
    n_chk  = 0;
    n_fail = 0;
    a_i    = '0;
    b_i    = '0;
    func_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // idle state: add of zeros
    check("R6 idle res", res_o, 16'h0000);
    check("R6 idle zero", {15'h0, zero_o}, 16'h1);
    check("R7 idle ovf", {15'h0, ovf_o}, 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < 15; i++) begin
      drive(VEC[i][35:34], VEC[i][33:26], VEC[i][25:18]);
      case (VEC[i][35:34])
        2'b00: begin
          check("R1/R5 add res", res_o, VEC[i][17:2]);
          check("R7 add ovf", {15'h0, ovf_o}, {15'h0, VEC[i][0]});
        end
        2'b01: begin
          check("R2/R5 xor res", res_o, VEC[i][17:2]);
          check("R8 xor ovf", {15'h0, ovf_o}, {15'h0, VEC[i][0]});
        end
        2'b10: begin
          check("R3/R5 pass res", res_o, VEC[i][17:2]);
          check("R8 pass ovf", {15'h0, ovf_o}, {15'h0, VEC[i][0]});
        end
        default: begin
          check("R4 mul res", res_o, VEC[i][17:2]);
          check("R9 mul ovf", {15'h0, ovf_o}, {15'h0, VEC[i][0]});
        end
      endcase
      check("R6 zero", {15'h0, zero_o}, {15'h0, VEC[i][1]});
    end

    // R3: a_i must not influence pass result
    drive(2'b10, 8'h00, 8'h5A);
    check("R3 pass a=00", res_o, 16'h005A);
    drive(2'b10, 8'hFF, 8'h5A);
    check("R3 pass a=FF", res_o, 16'h005A);

    // R10: inputs change between clock edges, outputs follow with no edge
    @(posedge clk);
    #1;
    func_i = 2'b11; a_i = 8'h03; b_i = 8'h05;
    #1;
    check("R10 comb mul", res_o, 16'h000F);
    a_i = 8'h00;
    #1;
    check("R10 comb zero", {15'h0, zero_o}, 16'h1);

    // sweep against model
    lfsr = 8'hB7;
    for (int k = 0; k < 400; k++) begin
      logic [7:0] bb;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bb   = lfsr ^ 8'(k * 37);
      drive(2'(k), lfsr, bb);
      e = model(2'(k), lfsr, bb);
      check("R1-4 sweep res", res_o, e[17:2]);
      check("R6 sweep zero", {15'h0, zero_o}, {15'h0, e[1]});
      check("R7/R8/R9 sweep ovf", {15'h0, ovf_o}, {15'h0, e[0]});
    end

    done = 1'b1;
    summary();
  end
endmodule